// File: doc/BRIEF.md
# Return Address Stack Predictor

This block predicts the target of procedure returns at the decode stage. The decode stage supplies class flags for the instruction it is decoding, a register number, and the return address that a call would produce (the call's PC plus 4 in 32-bit state or plus 2 in 16-bit state, computed upstream). A call pushes that return address onto a small circular stack. A recognised return pops the stack, and the entry it pops is offered as the predicted target together with a valid flag.

The stack contents are kept speculatively and are never copied. Only the stack position is checkpointed. Every decoded instruction sees the current position on `pred_ckpt`, and that value travels down the pipe with the instruction. If a conditional call or return later fails its condition, execute hands the checkpoint back on the fail port. If an instruction causes a flush, the flush port does the same. In both cases the position is rewound to the checkpoint. Unconditional instructions never come back on the fail port, so their stack operations always commit.

Execute also reports each resolved return on the check port: whether a prediction was made, what target was predicted, and the real target. The block raises `mispredict` when the prediction was missing or wrong.

Top module: `ras_predictor`

## Requirements
- R1: After reset the stack is empty. `pred_ckpt` reads 0 and `mispredict` is low.
- R2: A decoded call (`dec_call`=1) pushes `dec_ret_addr`. A later pop returns that address.
- R3: A decoded load to the PC (`dec_ld_pc`=1) pops only when `dec_reg` equals 13. With any other base register it leaves the stack unchanged.
- R4: A decoded branch-and-exchange (`dec_bx`=1) pops when `dec_reg` is 0 to 14. With `dec_reg`=15 it does not pop.
- R5: Pops return entries in last-in, first-out order. During a pop cycle, `pred_valid` is high and `pred_target` shows the entry being popped.
- R6: The stack holds 4 entries. A push onto a full stack overwrites the oldest entry, so the count never exceeds 4.
- R7: A pop from an empty stack drives `pred_valid` low and leaves the position unchanged.
- R8: `fail_valid` rewinds the position to `fail_ckpt` on the next clock edge. It takes priority over any decode in the same cycle.
- R9: `flush_valid` rewinds the position to `flush_ckpt` on the next clock edge. It takes priority over the fail port and over decode.
- R10: `mispredict` is high, in the same cycle, when `chk_valid` is high and either `chk_pred_valid` is low or `chk_pred_target` differs from `chk_actual_target`.
- R11: `pred_ckpt` is {count[2:0], top[1:0]}. Count is the number of live entries and top is the index of the newest entry. A push advances top by 1 mod 4; a pop moves it back by 1.
- R12: A cycle with `dec_valid` low, or with no call or return flag set, changes neither the position nor the prediction outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | Decode slot holds an instruction |
| dec_call | input | 1 | Instruction is a branch-with-link or link-and-exchange immediate |
| dec_ld_pc | input | 1 | Instruction is a load whose destination is the PC |
| dec_bx | input | 1 | Instruction is a branch-and-exchange |
| dec_reg | input | 4 | Base register (load) or source register (exchange) |
| dec_ret_addr | input | 32 | Return address for a call |
| pred_valid | output | 1 | Return prediction available |
| pred_target | output | 32 | Predicted return target |
| pred_ckpt | output | 5 | Current stack position, {count, top} |
| fail_valid | input | 1 | A conditional stack op failed its condition |
| fail_ckpt | input | 5 | Position recorded with the failed instruction |
| flush_valid | input | 1 | Pipeline flush |
| flush_ckpt | input | 5 | Position recorded with the flushing instruction |
| chk_valid | input | 1 | A return is resolved at execute |
| chk_pred_valid | input | 1 | A prediction was made for it |
| chk_pred_target | input | 32 | Target that was predicted |
| chk_actual_target | input | 32 | Target actually taken |
| mispredict | output | 1 | Return target was missing or wrong |

## Verification
The bench pushes five addresses so that the oldest entry is overwritten. A design that saturates instead of wrapping, or that lets the count grow past four, returns stale or extra entries on the pops that follow. It then pops past empty: a design that underflows would assert `pred_valid` or wrap the position.

Register 13 and register 15 are driven with the load and exchange flags to catch a decoder that is off by one in its return patterns. The flush and fail ports are driven in the same cycle as a decoded call, and together, which exposes a wrong priority that keeps a speculative push or picks the wrong checkpoint.

// File: rtl/ras_pkg.sv
package ras_pkg;
    parameter int RAS_DEPTH = 4;
    parameter int RAS_AW    = 32;
    localparam int RAS_PW   = $clog2(RAS_DEPTH);
    localparam int RAS_CW   = $clog2(RAS_DEPTH + 1);
    localparam int RAS_KW   = RAS_CW + RAS_PW;

    typedef struct packed {
        logic [RAS_CW-1:0] cnt;
        logic [RAS_PW-1:0] top;
    } ras_pos_t;
endpackage

// File: rtl/ras_classify.sv
module ras_classify (
    input  logic       dec_valid,
    input  logic       dec_call,
    input  logic       dec_ld_pc,
    input  logic       dec_bx,
    input  logic [3:0] dec_reg,
    output logic       push_req,
    output logic       pop_req
);
    localparam logic [3:0] SP_REG = 4'd13;
    localparam logic [3:0] PC_REG = 4'd15;

    logic ld_ret;
    logic bx_ret;

    always_comb begin
        ld_ret   = dec_ld_pc && (dec_reg == SP_REG);
        bx_ret   = dec_bx && (dec_reg != PC_REG);
        push_req = dec_valid && dec_call;
        pop_req  = dec_valid && !dec_call && (ld_ret || bx_ret);
    end
endmodule

// File: rtl/ras_entries.sv
module ras_entries #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_idx,
    input  logic [AW-1:0] wr_data,
    input  logic [PW-1:0] rd_idx,
    output logic [AW-1:0] rd_data
);
    logic [AW-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [AW-1:0] slot_d;
        always_comb begin
            slot_d = slot_q[g];
            if (wr_en && (wr_idx == PW'(g))) slot_d = wr_data;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot_q[g] <= '0;
            else        slot_q[g] <= slot_d;
        end
    end

    assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/ras_verify.sv
module ras_verify #(
    parameter int AW = 32
) (
    input  logic          chk_valid,
    input  logic          chk_pred_valid,
    input  logic [AW-1:0] chk_pred_target,
    input  logic [AW-1:0] chk_actual_target,
    output logic          mispredict
);
    always_comb begin
        mispredict = chk_valid &&
                     (!chk_pred_valid || (chk_pred_target != chk_actual_target));
    end
endmodule

// File: rtl/ras_predictor.sv
module ras_predictor
    import ras_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_valid,
    input  logic              dec_call,
    input  logic              dec_ld_pc,
    input  logic              dec_bx,
    input  logic [3:0]        dec_reg,
    input  logic [RAS_AW-1:0] dec_ret_addr,
    output logic              pred_valid,
    output logic [RAS_AW-1:0] pred_target,
    output logic [RAS_KW-1:0] pred_ckpt,
    input  logic              fail_valid,
    input  logic [RAS_KW-1:0] fail_ckpt,
    input  logic              flush_valid,
    input  logic [RAS_KW-1:0] flush_ckpt,
    input  logic              chk_valid,
    input  logic              chk_pred_valid,
    input  logic [RAS_AW-1:0] chk_pred_target,
    input  logic [RAS_AW-1:0] chk_actual_target,
    output logic              mispredict
);
    localparam logic [RAS_CW-1:0] FULL = RAS_CW'(RAS_DEPTH);

    ras_pos_t pos_d, pos_q;
    logic push_req, pop_req;
    logic wr_en;
    logic [RAS_PW-1:0] wr_idx;
    logic [RAS_AW-1:0] rd_data;

    ras_classify u_class (
        .dec_valid (dec_valid),
        .dec_call  (dec_call),
        .dec_ld_pc (dec_ld_pc),
        .dec_bx    (dec_bx),
        .dec_reg   (dec_reg),
        .push_req  (push_req),
        .pop_req   (pop_req)
    );

    ras_entries #(.DEPTH(RAS_DEPTH), .AW(RAS_AW)) u_entries (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (dec_ret_addr),
        .rd_idx  (pos_q.top),
        .rd_data (rd_data)
    );

    ras_verify #(.AW(RAS_AW)) u_verify (
        .chk_valid         (chk_valid),
        .chk_pred_valid    (chk_pred_valid),
        .chk_pred_target   (chk_pred_target),
        .chk_actual_target (chk_actual_target),
        .mispredict        (mispredict)
    );

    always_comb begin
        pos_d  = pos_q;
        wr_en  = 1'b0;
        wr_idx = pos_q.top + 1'b1;
        if (flush_valid) begin
            pos_d = ras_pos_t'(flush_ckpt);
        end else if (fail_valid) begin
            pos_d = ras_pos_t'(fail_ckpt);
        end else if (push_req) begin
            wr_en     = 1'b1;
            pos_d.top = wr_idx;
            if (pos_q.cnt != FULL) pos_d.cnt = pos_q.cnt + 1'b1;
        end else if (pop_req && (pos_q.cnt != '0)) begin
            pos_d.top = pos_q.top - 1'b1;
            pos_d.cnt = pos_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign pred_valid  = pop_req && (pos_q.cnt != '0);
    assign pred_target = rd_data;
    assign pred_ckpt   = pos_q;
endmodule

// File: rtl/ras_predictor_checks.sv
module ras_predictor_checks
    import ras_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              dec_valid,
    input logic              pred_valid,
    input logic [RAS_KW-1:0] pred_ckpt,
    input logic              fail_valid,
    input logic [RAS_KW-1:0] fail_ckpt,
    input logic              flush_valid,
    input logic [RAS_KW-1:0] flush_ckpt,
    input logic              chk_valid,
    input logic              chk_pred_valid,
    input logic              mispredict
);
    ras_pos_t cur;
    assign cur = ras_pos_t'(pred_ckpt);

    assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cur.cnt <= RAS_CW'(RAS_DEPTH));

    assert_empty_no_pred_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid |-> (cur.cnt != '0));

    assert_fail_rewind_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_valid && !flush_valid) |=> (pred_ckpt == $past(fail_ckpt)));

    assert_flush_rewind_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |=> (pred_ckpt == $past(flush_ckpt)));

    assert_missing_pred_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && !chk_pred_valid) |-> mispredict);

    assert_idle_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_valid && !fail_valid && !flush_valid) |=> $stable(pred_ckpt));
endmodule

bind ras_predictor ras_predictor_checks u_checks (
    .clk            (clk),
    .rst_n          (rst_n),
    .dec_valid      (dec_valid),
    .pred_valid     (pred_valid),
    .pred_ckpt      (pred_ckpt),
    .fail_valid     (fail_valid),
    .fail_ckpt      (fail_ckpt),
    .flush_valid    (flush_valid),
    .flush_ckpt     (flush_ckpt),
    .chk_valid      (chk_valid),
    .chk_pred_valid (chk_pred_valid),
    .mispredict     (mispredict)
);

// File: tb/ras_predictor_test.sv
module ras_predictor_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dec_valid = 0, dec_call = 0, dec_ld_pc = 0, dec_bx = 0;
    logic [3:0]  dec_reg = 0;
    logic [31:0] dec_ret_addr = 0;
    logic        pred_valid;
    logic [31:0] pred_target;
    logic [4:0]  pred_ckpt;
    logic        fail_valid = 0, flush_valid = 0;
    logic [4:0]  fail_ckpt = 0, flush_ckpt = 0;
    logic        chk_valid = 0, chk_pred_valid = 0;
    logic [31:0] chk_pred_target = 0, chk_actual_target = 0;
    logic        mispredict;

    int errors = 0;
    int checks = 0;

    // Behavioural reference: circular array with integer position
    int unsigned m_mem [4];
    int m_top = 0;
    int m_cnt = 0;

    ras_predictor uut (.*);

    always #10 clk = ~clk;

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #4000000;
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete");
        report();
    end

    task automatic expect_eq(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [4:0] m_ckpt();
        return {3'(m_cnt), 2'(m_top)};
    endfunction

    // One cycle: drive after negedge, compare before posedge, then advance model
    task automatic cyc(string req, bit v, bit call, bit ldpc, bit bx, int rg,
                       int unsigned addr, bit fl = 0, logic [4:0] flk = 0,
                       bit fa = 0, logic [4:0] fak = 0);
        bit m_pop;
        bit m_pv;
        @(negedge clk);
        dec_valid = v; dec_call = call; dec_ld_pc = ldpc; dec_bx = bx;
        dec_reg = 4'(rg); dec_ret_addr = addr;
        flush_valid = fl; flush_ckpt = flk; fail_valid = fa; fail_ckpt = fak;
        #5;
        m_pop = v && !call && ((ldpc && rg == 13) || (bx && rg != 15));
        m_pv  = m_pop && (m_cnt > 0);
        expect_eq(req, "pred_valid", pred_valid, m_pv);
        if (m_pv) expect_eq(req, "pred_target", pred_target, m_mem[m_top]);
        expect_eq("R11", "pred_ckpt", pred_ckpt, m_ckpt());
        @(posedge clk);
        if (fl) begin
            m_cnt = int'(flk[4:2]); m_top = int'(flk[1:0]);
        end else if (fa) begin
            m_cnt = int'(fak[4:2]); m_top = int'(fak[1:0]);
        end else if (v && call) begin
            m_top = (m_top + 1) % 4;
            m_mem[m_top] = addr;
            if (m_cnt < 4) m_cnt++;
        end else if (m_pop && m_cnt > 0) begin
            m_top = (m_top + 3) % 4;
            m_cnt--;
        end
    endtask

    task automatic chk(string req, bit pv, int unsigned pt, int unsigned at, bit exp);
        @(negedge clk);
        dec_valid = 0; flush_valid = 0; fail_valid = 0;
        chk_valid = 1; chk_pred_valid = pv; chk_pred_target = pt; chk_actual_target = at;
        #5;
        expect_eq(req, "mispredict", mispredict, exp);
        @(posedge clk);
        chk_valid = 0;
    endtask

    initial begin
        logic [4:0] saved;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #5;
        expect_eq("R1", "reset ckpt", pred_ckpt, 0);
        expect_eq("R1", "reset mispredict", mispredict, 0);
        cyc("R12", 0, 0, 0, 0, 0, 0);

        // R2: pushes
        cyc("R2", 1, 1, 0, 0, 0, 32'h1000);
        cyc("R2", 1, 1, 0, 0, 0, 32'h2004);
        cyc("R2", 1, 1, 0, 0, 0, 32'h3002);
        // R12: valid instruction with no class flag, and invalid slot with flags
        cyc("R12", 1, 0, 0, 0, 13, 0);
        cyc("R12", 0, 0, 1, 0, 13, 0);
        // R4 / R5: exchange from r14 pops newest
        cyc("R4", 1, 0, 0, 1, 14, 0);
        // R4: exchange from r15 is not a return
        cyc("R4", 1, 0, 0, 1, 15, 0);
        // R3: load to PC with base r12 is not a return
        cyc("R3", 1, 0, 1, 0, 12, 0);
        // R3 / R5: load with base r13 pops
        cyc("R3", 1, 0, 1, 0, 13, 0);
        cyc("R4", 1, 0, 0, 1, 0, 0);
        // R7: pops past empty
        cyc("R7", 1, 0, 0, 1, 3, 0);
        cyc("R7", 1, 0, 1, 0, 13, 0);

        // R6: five pushes wrap over the oldest entry
        for (int i = 0; i < 5; i++) cyc("R6", 1, 1, 0, 0, 0, 32'hA000 + i * 4);
        for (int i = 0; i < 5; i++) cyc("R6", 1, 0, 1, 0, 13, 0);

        // R8: conditional call rewound by the fail port
        cyc("R8", 1, 1, 0, 0, 0, 32'hB000);
        saved = m_ckpt();
        cyc("R8", 1, 1, 0, 0, 0, 32'hB100);
        cyc("R8", 1, 1, 0, 0, 0, 32'hB200, 0, 0, 1, saved);
        cyc("R8", 1, 0, 0, 1, 2, 0);

        // R9: flush beats fail and decode in the same cycle
        cyc("R9", 1, 1, 0, 0, 0, 32'hC000);
        cyc("R9", 1, 1, 0, 0, 0, 32'hC100);
        saved = m_ckpt();
        cyc("R9", 1, 0, 0, 1, 5, 0);
        cyc("R9", 1, 1, 0, 0, 0, 32'hC200, 1, saved, 1, 5'd0);
        cyc("R9", 1, 0, 0, 1, 5, 0);
        cyc("R9", 1, 0, 0, 1, 5, 0);
        cyc("R9", 0, 0, 0, 0, 0, 0, 1, 5'd0);
        cyc("R7", 1, 0, 0, 1, 5, 0);

        // R10: mispredict checks
        chk("R10", 1, 32'h44, 32'h44, 0);
        chk("R10", 1, 32'h44, 32'h48, 1);
        chk("R10", 0, 32'h44, 32'h44, 1);
        @(negedge clk);
        chk_valid = 0; chk_pred_valid = 1; chk_pred_target = 1; chk_actual_target = 2;
        #5;
        expect_eq("R10", "mispredict idle", mispredict, 0);

        report();
    end
endmodule